// File: doc/BRIEF.md
# Two-Dimensional Address Generator with End-of-Structure Tags

This unit walks a data structure stored in a separate memory and emits one address per token. The walk covers either a single vector or a grid of rows. Each address is the sum of three terms: a base, the row index times a row stride, and the column index. The column index moves fastest. A control processor loads four configuration registers over a small write bus: the base, the stride, the row length and the row count. It then pulses `start`.

Addresses leave through a valid/ready handshake. Each address carries a two-bit tag. Downstream data-driven logic uses the tag to tell where a row ends and where the whole structure ends. After the final address is accepted, the unit drops back to idle and sets a sticky interrupt flag. The next accepted configuration write clears that flag.

Top module: `agu2d_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `addr_valid`, `busy` and `irq` are 0.
- R2: `cfg_sel` chooses the register that a write loads: 0 is the base, 1 is the row stride, 2 is the row length (columns) and 3 is the row count. Token number k, with row r = k / length and column c = k % length, has the address (base + r*stride + c) taken modulo 2^ADDR_W. The column index moves fastest.
- R3: `addr_tag` is a two-bit field. The value 0 marks an ordinary token. The value 1 marks the last column of a row that is not the final row. The value 2 marks the final token of the structure. The value 3 never appears.
- R4: When the row count is 1, the single vector's last token carries tag 2, and none of its tokens carries tag 1.
- R5: A token advances only on a cycle where `addr_valid` and `addr_ready` are both 1. While the handshake is stalled, `addr_out` and `addr_tag` hold their values.
- R6: A `start` pulse taken while idle, with both counts nonzero, makes `addr_valid` 1 on the next cycle. Exactly length × count tokens are then emitted, with no gap caused by the unit.
- R7: On the cycle after the final token is accepted, `addr_valid` and `busy` are 0 and `irq` is 1. `irq` then stays 1 until it is cleared.
- R8: A configuration write accepted while idle clears `irq`.
- R9: A configuration write made while `busy` is 1 changes no register. The run in progress and the next run use the old values.
- R10: A `start` pulse made while `busy` is 1 has no effect on the token sequence in progress.
- R11: A `start` pulse while the row length or the row count is 0 is ignored. `addr_valid` stays 0 and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 stride, 2 length, 3 count) |
| cfg_wdata | input | DATA_W | Configuration write data |
| start | input | 1 | Request pulse that starts a walk |
| addr_out | output | ADDR_W | Current address |
| addr_tag | output | 2 | End-of-structure tag for the current address |
| addr_valid | output | 1 | Address is valid |
| addr_ready | input | 1 | Consumer accepts the address |
| busy | output | 1 | A walk is in progress |
| irq | output | 1 | Sticky completion flag |

## Verification
A configuration write lands on the clock edge after it is driven. A start pulse shows `addr_valid` one edge later. The address and tag of the current token are combinational from registered indices, so they can be read in the same half-cycle as `addr_valid`. Completion flags appear one edge after the final handshake. The bench drives every input on the falling edge and samples the outputs there too. It compares each token before the rising edge that consumes it, and checks each stalled token against the value it recorded one falling edge earlier. The completion checks run at the first falling edge after the final accepting edge.

// File: rtl/agu2d_pkg.sv
package agu2d_pkg;
  typedef enum logic [1:0] {
    TAG_MID = 2'd0,
    TAG_ROW = 2'd1,
    TAG_END = 2'd2
  } tag_e;

  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_STRIDE = 2'd1,
    SEL_LEN    = 2'd2,
    SEL_ROWS   = 2'd3
  } sel_e;

  function automatic tag_e tag_of(input logic row_end, input logic all_end);
    if (all_end)      tag_of = TAG_END;
    else if (row_end) tag_of = TAG_ROW;
    else              tag_of = TAG_MID;
  endfunction
endpackage

// File: rtl/agu2d_cfg.sv
module agu2d_cfg #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] stride_q,
  output logic [CNT_W-1:0]  len_q,
  output logic [CNT_W-1:0]  rows_q
);
  import agu2d_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      rows_q   <= '0;
    end else if (wr_ok) begin
      unique case (sel_e'(sel))
        SEL_BASE:   base_q   <= wdata[ADDR_W-1:0];
        SEL_STRIDE: stride_q <= wdata[ADDR_W-1:0];
        SEL_LEN:    len_q    <= wdata[CNT_W-1:0];
        SEL_ROWS:   rows_q   <= wdata[CNT_W-1:0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/agu2d_seq.sv
module agu2d_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             fire,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] rows,
  output logic             busy_q,
  output logic [CNT_W-1:0] col_q,
  output logic [CNT_W-1:0] row_q,
  output logic             row_end,
  output logic             all_end
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign row_end = (col_q == len - ONE);
  assign all_end = row_end && (row_q == rows - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      col_q  <= '0;
      row_q  <= '0;
    end else if (fire) begin
      if (all_end) begin
        busy_q <= 1'b0;
      end else if (row_end) begin
        col_q <= '0;
        row_q <= row_q + ONE;
      end else begin
        col_q <= col_q + ONE;
      end
    end
  end
endmodule

// File: rtl/agu2d_emit.sv
module agu2d_emit #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [CNT_W-1:0]  col,
  input  logic [CNT_W-1:0]  row,
  input  logic              row_end,
  input  logic              all_end,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        tag
);
  import agu2d_pkg::*;

  function automatic logic [ADDR_W-1:0] addr_of(
    input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s,
    input logic [CNT_W-1:0] r, input logic [CNT_W-1:0] c);
    addr_of = b + ADDR_W'(r) * s + ADDR_W'(c);
  endfunction

  always_comb begin
    addr = addr_of(base, stride, row, col);
    tag  = tag_of(row_end, all_end);
  end
endmodule

// File: rtl/agu2d_top.sv
module agu2d_top #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              start,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        addr_tag,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic              busy,
  output logic              irq
);
  logic [ADDR_W-1:0] base_q, stride_q;
  logic [CNT_W-1:0]  len_q, rows_q, col_q, row_q;
  logic              busy_q, row_end, all_end;
  logic              wr_ok, go, fire, irq_q;

  // named internal events
  assign wr_ok = cfg_we && !busy_q;
  assign go    = start && !busy_q && (len_q != '0) && (rows_q != '0);
  assign fire  = busy_q && addr_ready;

  agu2d_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_q(base_q), .stride_q(stride_q), .len_q(len_q), .rows_q(rows_q));

  agu2d_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .fire(fire), .len(len_q), .rows(rows_q),
    .busy_q(busy_q), .col_q(col_q), .row_q(row_q),
    .row_end(row_end), .all_end(all_end));

  agu2d_emit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_emit (
    .base(base_q), .stride(stride_q), .col(col_q), .row(row_q),
    .row_end(row_end), .all_end(all_end), .addr(addr_out), .tag(addr_tag));

  always_ff @(posedge clk) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (fire && all_end)  irq_q <= 1'b1;
    else if (wr_ok)            irq_q <= 1'b0;
  end

  assign addr_valid = busy_q;
  assign busy       = busy_q;
  assign irq        = irq_q;
endmodule

// File: rtl/agu2d_chk.sv
module agu2d_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cfg_we,
  input logic              busy,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        addr_tag,
  input logic              irq,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] stride_q,
  input logic [CNT_W-1:0]  len_q,
  input logic [CNT_W-1:0]  rows_q
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_out) && $stable(addr_tag)); // R5
  AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> addr_tag != 2'd3); // R3
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && addr_tag == 2'd2 |=> irq && !addr_valid && !busy); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cfg_we |=> irq); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !busy && !(addr_valid && addr_ready) |=> !irq); // R8
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we |=> $stable(base_q) && $stable(stride_q) && $stable(len_q) && $stable(rows_q)); // R9
  AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && len_q != '0 && rows_q != '0 && !cfg_we |=> addr_valid); // R6
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (len_q == '0 || rows_q == '0) |=> !addr_valid); // R11
endmodule

bind agu2d_top agu2d_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we), .busy(busy),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
  .addr_tag(addr_tag), .irq(irq), .base_q(base_q), .stride_q(stride_q),
  .len_q(len_q), .rows_q(rows_q));

// File: tb/sim_agu2d_top.sv
module sim_agu2d_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        start = 1'b0;
  logic        addr_ready = 1'b0;
  logic [15:0] addr_out;
  logic [1:0]  addr_tag;
  logic        addr_valid, busy, irq;

  always #4 clk = ~clk;

  agu2d_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .addr_out(addr_out),
    .addr_tag(addr_tag), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .busy(busy), .irq(irq));

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] stride;
    logic [7:0]  len;
    logic [7:0]  rows;
    logic [7:0]  mask;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'd100,  16'd16,  8'd4, 8'd3, 8'hFF},  // plain grid
    '{16'h0020, 16'd8,   8'd5, 8'd1, 8'hB6},  // single vector, stalls
    '{16'hFFF0, 16'h0010,8'd3, 8'd2, 8'hFF},  // wraps past 2^16
    '{16'd7,    16'd0,   8'd2, 8'd3, 8'h55},  // zero stride
    '{16'd0,    16'd100, 8'd1, 8'd4, 8'hCC}   // one column per row
  };

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] cb, cs;
  logic [7:0]  ci, co;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input bit do_cfg, input vec_t v, input bit inject);
    int idx = 0, cyc = 0, total, r, c, ea, et;
    bit pstall = 1'b0;
    logic [15:0] paddr;
    logic [1:0]  ptag;
    if (do_cfg) begin
      cfg_wr(2'd0, v.base); cfg_wr(2'd1, v.stride);
      cfg_wr(2'd2, 16'(v.len)); cfg_wr(2'd3, 16'(v.rows));
      cb = v.base; cs = v.stride; ci = v.len; co = v.rows;
      chk(irq == 1'b0, "R8 irq cleared by write", int'(irq), 0);
    end
    total = int'(ci) * int'(co);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(addr_valid == 1'b1, "R6 valid one cycle after start", int'(addr_valid), 1);
    while (idx < total && cyc < 4000) begin
      addr_ready = v.mask[cyc % 8];
      if (inject && cyc == 1) begin  // R9 R10: write and start while busy
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'hABCD; start = 1'b1;
      end
      if (pstall) begin
        chk(addr_out == paddr, "R5 address held in stall", int'(addr_out), int'(paddr));
        chk(addr_tag == ptag, "R5 tag held in stall", int'(addr_tag), int'(ptag));
      end
      if (!addr_valid) begin
        chk(1'b0, "R6 valid dropped before last token", idx, total);
      end else if (addr_ready) begin
        r = idx / int'(ci); c = idx % int'(ci);
        ea = (int'(cb) + r * int'(cs) + c) & 16'hFFFF;
        et = (c == int'(ci) - 1) ? ((r == int'(co) - 1) ? 2 : 1) : 0;
        chk(addr_out == 16'(ea), "R2 address", int'(addr_out), ea);
        chk(addr_tag == 2'(et), (co == 8'd1) ? "R4 tag of vector" : "R3 tag",
            int'(addr_tag), et);
        idx++;
      end
      pstall = addr_valid && !addr_ready;
      paddr = addr_out; ptag = addr_tag;
      @(negedge clk);
      cfg_we = 1'b0; start = 1'b0;
      cyc++;
    end
    addr_ready = 1'b0;
    chk(addr_valid == 1'b0 && busy == 1'b0, "R7 idle after last token",
        int'({addr_valid, busy}), 0);
    chk(irq == 1'b1, "R7 irq set after last token", int'(irq), 1);
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq sticky", int'(irq), 1);
    chk(addr_valid == 1'b0, "R6 no extra token", int'(addr_valid), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 run hung actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(addr_valid == 0 && busy == 0 && irq == 0, "R1 reset state",
        int'({addr_valid, busy, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_valid == 0 && busy == 0 && irq == 0, "R1 after release",
        int'({addr_valid, busy, irq}), 0);

    foreach (VECS[k]) run(1'b1, VECS[k], 1'b0);

    // R9 R10: busy-time write and start have no effect on this or next run
    run(1'b1, VECS[0], 1'b1);
    chk(cb == 16'd100, "R9 bench config kept", int'(cb), 100);
    run(1'b0, VECS[0], 1'b0);

    // R11: zero length ignores start
    cfg_wr(2'd2, 16'd0);
    chk(irq == 1'b0, "R8 irq cleared", int'(irq), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < 4; j++) begin
      chk(addr_valid == 1'b0 && busy == 1'b0, "R11 no run on zero length",
          int'(addr_valid), 0);
      @(negedge clk);
    end
    chk(irq == 1'b0, "R11 no irq on zero length", int'(irq), 0);
    cfg_wr(2'd2, 16'd3); cfg_wr(2'd3, 16'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(addr_valid == 1'b0 && irq == 1'b0, "R11 no run on zero rows",
        int'({addr_valid, irq}), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule